// File: doc/BRIEF.md
# Frame Data Fault Injector

This block sits inline on a byte-wide stream of frame data and deliberately corrupts it, so that a downstream integrity checker can be exercised with known faults. Each byte arrives with a valid flag, a start-of-frame flag and an end-of-frame flag. The block passes the stream through with one register stage. In one chosen frame it XORs an error pattern into one byte, or into a pair of neighbouring bits.

A host loads a 21-bit fault word serially into a staging register, one bit per enabled cycle, at any time. The staged word becomes the active word only at the boundary where the stream wraps from its last frame back to its first frame. The source marks that boundary with a wrap pulse, and the frame that starts after reset also counts as a first frame. Only the first frame after such a boundary is corrupted. Loading an all-zero word at a boundary disarms the injector.

Top module: `frame_fault_injector`

## Requirements
- R1: While reset is asserted and after it is released with no input, out_valid, out_sof and out_eof are 0 and out_data is 0.
- R2: Each input byte appears on the outputs exactly one cycle later, with its valid, start and end flags. The data is unchanged unless R4 or R5 applies.
- R3: The fault word is shifted in MSB first: on each cycle with host_shift_en high, host_shift_bit enters bit 0 and the older bits move up. Field layout: bits 20:19 are the kind, bits 18:8 the target byte index, bits 7:0 the error byte.
- R4: Kind 01 (single): in a first frame, the byte whose index equals the target index is XORed with the error byte. Word 0x080440 flips bit 6 of the fifth byte (index 4).
- R5: Kind 10 (pair): the target byte is XORed with the error byte. If the error byte is exactly 0x01 and the target index is not 0, bit 7 of the byte at index target-1 is also flipped. In every other case only the target byte changes.
- R6: Kind 00 and kind 11 cause no corruption.
- R7: The staged word is copied into the active word only on the start-of-frame byte of a first frame. A staging write during a frame does not change that frame's corruption.
- R8: A first frame is the first frame after reset, or the first frame whose start follows a wrap pulse. A wrap pulse in the same cycle as the start byte also counts. All other frames pass through unchanged.
- R9: The byte index is 0 on the start-of-frame byte and advances only on bytes with in_valid high.
- R10: An all-zero staged word loaded at a boundary clears the active word, and later first frames are not corrupted.
- R11: If a host shift and a boundary load fall in the same cycle, the active word takes the staged value from before that shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| host_shift_en | input | 1 | Shift one bit into the staging register |
| host_shift_bit | input | 1 | Serial bit of the fault word |
| in_valid | input | 1 | Input byte valid |
| in_sof | input | 1 | Input byte is the first of a frame |
| in_eof | input | 1 | Input byte is the last of a frame |
| in_wrap | input | 1 | Pulse: the next frame is the first frame |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte valid |
| out_sof | output | 1 | Output start-of-frame flag |
| out_eof | output | 1 | Output end-of-frame flag |
| out_data | output | 8 | Output byte, possibly corrupted |

## Verification
The staging shift path and the boundary load are independent. They can land on the same clock edge when the host's last serial bit arrives with the start byte of a first frame. The bench builds that collision: it clears the staging register and then shifts a word whose shifted-by-one image is a different valid fault word. The final bit is timed to coincide with the start byte. The corruption seen in that frame must match the pre-shift image, and the complete word must appear only in the next first frame. A staging write is also spread across the body of a first frame, to show that the running frame keeps its original fault.

// File: rtl/ffi_pkg.sv
package ffi_pkg;
  typedef enum logic [1:0] {
    FI_OFF    = 2'b00,
    FI_SINGLE = 2'b01,
    FI_PAIR   = 2'b10,
    FI_RSVD   = 2'b11
  } fi_kind_e;

  function automatic logic fi_kind_live(input logic [1:0] k);
    return (k == FI_SINGLE) || (k == FI_PAIR);
  endfunction
endpackage

// File: rtl/fi_host_stage.sv
module fi_host_stage #(
  parameter int CFG_W = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             shift_bit,
  output logic [CFG_W-1:0] staged
);
  always_ff @(posedge clk) begin
    if (!rst_n)        staged <= '0;
    else if (shift_en) staged <= {staged[CFG_W-2:0], shift_bit};
  end
endmodule

// File: rtl/fi_frame_track.sv
module fi_frame_track #(
  parameter int LOC_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_wrap,
  output logic [LOC_W-1:0] byte_idx,
  output logic             first_now,
  output logic             load_stb
);
  logic             pend_q;
  logic             first_q;
  logic [LOC_W-1:0] cnt_q;
  logic             sof_v;

  assign sof_v     = in_valid & in_sof;
  assign load_stb  = sof_v & (pend_q | in_wrap);
  assign first_now = sof_v ? load_stb : first_q;
  assign byte_idx  = sof_v ? '0 : cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= 1'b1;
      first_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      pend_q <= sof_v ? 1'b0 : (pend_q | in_wrap);
      if (sof_v) first_q <= load_stb;
      if (in_valid) begin
        if (sof_v)            cnt_q <= LOC_W'(1);
        else if (cnt_q != '1) cnt_q <= cnt_q + LOC_W'(1);
      end
    end
  end
endmodule

// File: rtl/fi_corrupt.sv
module fi_corrupt
  import ffi_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LOC_W  = 11,
  localparam int CFG_W = 2 + LOC_W + DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CFG_W-1:0]  staged,
  input  logic              load_stb,
  input  logic              first_now,
  input  logic [LOC_W-1:0]  byte_idx,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic              out_sof,
  output logic              out_eof,
  output logic [DATA_W-1:0] out_data,
  output logic [CFG_W-1:0]  active_cfg,
  output logic [1:0]        eff_kind,
  output logic [LOC_W-1:0]  eff_loc,
  output logic [DATA_W-1:0] eff_val
);
  logic [CFG_W-1:0]  active_q;
  logic [CFG_W-1:0]  eff_cfg;
  logic [DATA_W-1:0] mask;

  function automatic logic [DATA_W-1:0] flip_mask(
    input logic [1:0]        kind,
    input logic [LOC_W-1:0]  loc,
    input logic [DATA_W-1:0] val,
    input logic [LOC_W-1:0]  idx
  );
    logic [DATA_W-1:0] m;
    logic              lone_low;
    m        = '0;
    lone_low = (val == DATA_W'(1));
    if (fi_kind_live(kind) && idx == loc) m = val;
    if (kind == FI_PAIR && lone_low && loc != '0 && idx == loc - LOC_W'(1))
      m = {1'b1, {(DATA_W-1){1'b0}}};
    return m;
  endfunction

  assign eff_cfg    = load_stb ? staged : active_q;
  assign eff_kind   = eff_cfg[CFG_W-1 -: 2];
  assign eff_loc    = eff_cfg[DATA_W +: LOC_W];
  assign eff_val    = eff_cfg[DATA_W-1:0];
  assign active_cfg = active_q;
  assign mask       = first_now ? flip_mask(eff_kind, eff_loc, eff_val, byte_idx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q  <= '0;
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
      out_data  <= '0;
    end else begin
      if (load_stb) active_q <= staged;
      out_valid <= in_valid;
      out_sof   <= in_valid & in_sof;
      out_eof   <= in_valid & in_eof;
      out_data  <= in_valid ? (in_data ^ mask) : '0;
    end
  end
endmodule

// File: rtl/frame_fault_injector.sv
module frame_fault_injector #(
  parameter int DATA_W = 8,
  parameter int LOC_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_shift_en,
  input  logic              host_shift_bit,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic              in_wrap,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic              out_sof,
  output logic              out_eof,
  output logic [DATA_W-1:0] out_data
);
  localparam int CFG_W = 2 + LOC_W + DATA_W;

  logic [CFG_W-1:0]  staged;
  logic [CFG_W-1:0]  active_cfg;
  logic [LOC_W-1:0]  byte_idx;
  logic              first_now;
  logic              load_stb;
  logic [1:0]        eff_kind;
  logic [LOC_W-1:0]  eff_loc;
  logic [DATA_W-1:0] eff_val;

  fi_host_stage #(.CFG_W(CFG_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .shift_en(host_shift_en),
    .shift_bit(host_shift_bit), .staged(staged)
  );

  fi_frame_track #(.LOC_W(LOC_W)) u_track (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_wrap(in_wrap), .byte_idx(byte_idx), .first_now(first_now),
    .load_stb(load_stb)
  );

  fi_corrupt #(.DATA_W(DATA_W), .LOC_W(LOC_W)) u_corrupt (
    .clk(clk), .rst_n(rst_n), .staged(staged), .load_stb(load_stb),
    .first_now(first_now), .byte_idx(byte_idx), .in_valid(in_valid),
    .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
    .out_valid(out_valid), .out_sof(out_sof), .out_eof(out_eof),
    .out_data(out_data), .active_cfg(active_cfg), .eff_kind(eff_kind),
    .eff_loc(eff_loc), .eff_val(eff_val)
  );
endmodule

// File: rtl/ffi_checker.sv
module ffi_checker #(
  parameter int DATA_W = 8,
  parameter int LOC_W  = 11,
  localparam int CFG_W = 2 + LOC_W + DATA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_shift_en,
  input logic              host_shift_bit,
  input logic              in_valid,
  input logic              in_sof,
  input logic              in_eof,
  input logic [DATA_W-1:0] in_data,
  input logic              out_valid,
  input logic              out_sof,
  input logic              out_eof,
  input logic [DATA_W-1:0] out_data,
  input logic [CFG_W-1:0]  staged,
  input logic [CFG_W-1:0]  active_cfg,
  input logic [LOC_W-1:0]  byte_idx,
  input logic              first_now,
  input logic              load_stb,
  input logic [1:0]        eff_kind,
  input logic [LOC_W-1:0]  eff_loc,
  input logic [DATA_W-1:0] eff_val
);
  AST_FLAGS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid && out_sof == $past(in_sof) && out_eof == $past(in_eof)); // R2

  AST_STAGE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    host_shift_en |=> staged[0] == $past(host_shift_bit)); // R3

  AST_SINGLE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && first_now && eff_kind == 2'b01 && byte_idx == eff_loc
      |=> out_data == ($past(in_data) ^ $past(eff_val))); // R4

  AST_DEAD_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (eff_kind == 2'b00 || eff_kind == 2'b11) |=> out_data == $past(in_data)); // R6

  AST_HOLD_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !load_stb |=> $stable(active_cfg)); // R7

  AST_LATER_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !first_now |=> out_data == $past(in_data)); // R8

  AST_IDX_START: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_sof |-> byte_idx == '0); // R9

  AST_LOAD_PRESHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> active_cfg == $past(staged)); // R11
endmodule

bind frame_fault_injector ffi_checker #(.DATA_W(DATA_W), .LOC_W(LOC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_shift_en(host_shift_en),
  .host_shift_bit(host_shift_bit), .in_valid(in_valid), .in_sof(in_sof),
  .in_eof(in_eof), .in_data(in_data), .out_valid(out_valid),
  .out_sof(out_sof), .out_eof(out_eof), .out_data(out_data),
  .staged(staged), .active_cfg(active_cfg), .byte_idx(byte_idx),
  .first_now(first_now), .load_stb(load_stb), .eff_kind(eff_kind),
  .eff_loc(eff_loc), .eff_val(eff_val)
);

// File: tb/frame_fault_injector_test.sv
module frame_fault_injector_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_shift_en = 1'b0, host_shift_bit = 1'b0;
  logic       in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0, in_wrap = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       out_valid, out_sof, out_eof;
  logic [7:0] out_data;

  always #5 clk = ~clk;

  frame_fault_injector uut (
    .clk(clk), .rst_n(rst_n), .host_shift_en(host_shift_en),
    .host_shift_bit(host_shift_bit), .in_valid(in_valid), .in_sof(in_sof),
    .in_eof(in_eof), .in_wrap(in_wrap), .in_data(in_data),
    .out_valid(out_valid), .out_sof(out_sof), .out_eof(out_eof),
    .out_data(out_data)
  );

  typedef struct {
    logic       sof;
    logic       eof;
    logic [7:0] data;
    string      req;
  } exp_t;

  exp_t  sb[$];
  int    n_chk = 0, n_fail = 0;
  bit    done = 1'b0;
  string cur_req = "R2";

  // Reference model state, built from the requirements
  logic [20:0] m_staged = '0, m_active = '0;
  bit          m_pend = 1'b1, m_first = 1'b0;
  int          m_cnt = 0;

  function automatic logic [7:0] want_mask(logic [20:0] w, int idx);
    int         loc;
    logic [1:0] kind;
    logic [7:0] v;
    kind = w[20:19];
    loc  = int'(w[18:8]);
    v    = w[7:0];
    if (kind == 2'b01) return (idx == loc) ? v : 8'h00;          // R4
    if (kind == 2'b10) begin                                        // R5
      if (idx == loc) return v;
      if (v == 8'h01 && loc > 0 && idx + 1 == loc) return 8'h80;
    end
    return 8'h00;                                                   // R6
  endfunction

  task automatic cyc(bit v, bit s, bit e, bit w, logic [7:0] d, bit she = 0, bit shb = 0);
    int idx;
    @(negedge clk);
    in_valid = v; in_sof = s; in_eof = e; in_wrap = w; in_data = d;
    host_shift_en = she; host_shift_bit = shb;
    if (v && s) begin
      m_first = m_pend || w;                 // R8
      if (m_first) m_active = m_staged;      // R7, R11: pre-shift value
      m_pend = 1'b0;
    end else if (w) m_pend = 1'b1;
    idx = (v && s) ? 0 : m_cnt;              // R9
    if (v) begin
      sb.push_back('{s, e, d ^ (m_first ? want_mask(m_active, idx) : 8'h00), cur_req});
      m_cnt = s ? 1 : m_cnt + 1;
    end
    if (she) m_staged = {m_staged[19:0], shb}; // R3
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 8'h00);
  endtask

  task automatic write_word(logic [20:0] w);
    for (int i = 20; i >= 0; i--) cyc(0, 0, 0, 0, 8'h00, 1, w[i]);
  endtask

  task automatic frame(int n, bit wrap, bit gaps = 0, logic [7:0] seed = 8'h11);
    for (int i = 0; i < n; i++) begin
      cyc(1, i == 0, i == n - 1, wrap && i == 0, seed + 8'(i * 29));
      if (gaps && (i % 2 == 1)) idle(2);
    end
    idle(2);
  endtask

  // Monitor: pop the scoreboard as results emerge
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        n_chk++;
        if (sb.size() == 0) begin
          n_fail++;
          $display("FAIL R2: unexpected output byte %h, expected none", out_data);
        end else begin
          exp_t e;
          e = sb.pop_front();
          if (out_sof !== e.sof || out_eof !== e.eof || out_data !== e.data) begin
            n_fail++;
            $display("FAIL %s: got sof=%b eof=%b data=%h, expected sof=%b eof=%b data=%h",
                     e.req, out_sof, out_eof, out_data, e.sof, e.eof, e.data);
          end
        end
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0 || out_sof !== 1'b0 || out_eof !== 1'b0 || out_data !== 8'h00) begin
      n_fail++;
      $display("FAIL R1: got v=%b s=%b e=%b d=%h, expected 0 0 0 00",
               out_valid, out_sof, out_eof, out_data);
    end
    rst_n = 1'b1;
    idle(2);
    n_chk++;
    if (out_valid !== 1'b0 || out_data !== 8'h00) begin
      n_fail++;
      $display("FAIL R1: after release got v=%b d=%h, expected 0 00", out_valid, out_data);
    end

    // R2 / R6: first frame after reset with an all-zero word: clean pass
    cur_req = "R2"; frame(8, 0);

    // R4: single flip, word 0x080440 -> byte 4 bit 6
    write_word(21'h080440);
    cur_req = "R4"; frame(8, 1);
    // R8: next frame without wrap is clean
    cur_req = "R8"; frame(8, 0, 0, 8'h3C);
    // R9: gaps in valid do not advance the index
    cur_req = "R9"; frame(8, 1, 1, 8'h5A);

    // R7: staging write spread across a first frame
    cur_req = "R7";
    for (int i = 0; i < 30; i++) begin
      logic [20:0] nw;
      nw = 21'h0801FF;
      cyc(1, i == 0, i == 29, i == 0, 8'h20 + 8'(i),
          (i >= 3 && i < 24), (i >= 3 && i < 24) ? nw[23 - i] : 1'b0);
    end
    idle(2);
    frame(8, 1, 0, 8'h77);   // new word: byte 1 ^ FF

    // R5: pair kind, carry into previous byte, no carry, and index 0
    cur_req = "R5";
    write_word(21'h100301); frame(8, 1);
    write_word(21'h100318); frame(8, 1);
    write_word(21'h100001); frame(8, 1);

    // R6: kind 11 is invalid: no corruption
    cur_req = "R6";
    write_word(21'h1805FF); frame(8, 1);

    // R11: last host shift coincides with the first-frame start byte
    cur_req = "R11";
    write_word(21'h000000);
    cyc(0, 0, 0, 1, 8'h00);          // wrap pulse ahead of the frame
    begin
      logic [20:0] b;
      b = 21'h100440;                 // pre-shift image is 0x080220
      for (int i = 20; i >= 1; i--) cyc(0, 0, 0, 0, 8'h00, 1, b[i]);
      cyc(1, 1, 0, 0, 8'h90, 1, b[0]);
      for (int i = 1; i < 8; i++) cyc(1, 0, i == 7, 0, 8'h90 + 8'(i * 13));
      idle(2);
    end
    frame(8, 1, 0, 8'hC3);           // full word now active

    // R10: all-zero word clears the injector
    cur_req = "R10";
    write_word(21'h000000);
    frame(8, 1);
    frame(8, 1, 0, 8'hE1);

    idle(4);
    n_chk++;
    if (sb.size() != 0) begin
      n_fail++;
      $display("FAIL R2: %0d bytes never emerged, expected 0", sb.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule